// File: doc/BRIEF.md
# Multi-Function Pad Control Cell

This cell sits between one external pad and eight internal peripherals that may each want to use it. A 32-bit configuration word, written through a simple write port and always visible on a read-back output, picks which of the eight alternate functions owns the pad. It also sets how the pad's pull resistors are controlled and which edges of the pad input are watched. The selected function's output value and output enable reach the pad. The pad input level is handed unchanged to every function.

While the chip is in a low-power state, the configuration can replace the function's drive with a fixed data value and output enable. The pad input passes through a synchronizer and is watched for rising and falling edges. An edge on an enabled polarity sets a sticky event flag. That flag becomes a wake request only when an external per-source wake enable is also high. A three-bit drive-strength code is stored and presented on an output for the analog pad. It does nothing else inside the cell.

Top module: `pad_mux_cell`

## Requirements
- R1: After reset the configuration reads 0, the event flag and wake request are 0, and alternate function 0 drives the pad.
- R2: A write stores bits 15:4 and 2:0 of the write data. Bits 31:16 and bit 3 always read back as 0, whatever was written.
- R3: Bits 2:0 select function N (0 to 7). Outside the low-power override, padOut equals funcOut[N] and padOe equals funcOe[N].
- R4: When bit 15 is 0, the pad pulls follow funcPullUp[N] and funcPullDn[N]. When bit 15 is 1, the pull-up follows bit 14 and the pull-down follows bit 13.
- R5: When lowPowerMode is 1 and bit 9 is 1, padOut equals bit 8 and padOe equals the inverse of bit 7. When lowPowerMode is 1 and bit 9 is 0, the function path stays in control.
- R6: With bit 4 set, a rising edge on padIn sets edgeFlag on the third rising clock edge after the change: two synchronizer flops and then the flag register.
- R7: With bit 5 set, a falling edge on padIn sets edgeFlag with the same latency. With both bits set, either edge sets it.
- R8: edgeFlag stays set until it is cleared. An edge whose polarity is not enabled does not set it.
- R9: Writing a 1 to bit 6 clears edgeFlag on the next clock. While bit 6 stays set, no edge sets the flag.
- R10: wakeReq is 1 exactly when edgeFlag is 1 and wakeEnable is 1.
- R11: driveCode always equals configuration bits 12:10.
- R12: Each bit of funcIn equals the raw padIn level, whichever function is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Configuration read-back |
| lowPowerMode | input | 1 | Chip is in a low-power state |
| wakeEnable | input | 1 | Per-source wake enable |
| funcOut | input | 8 | Output value from each alternate function |
| funcOe | input | 8 | Output enable from each alternate function |
| funcPullUp | input | 8 | Pull-up request from each alternate function |
| funcPullDn | input | 8 | Pull-down request from each alternate function |
| padIn | input | 1 | Level sensed at the pad |
| padOut | output | 1 | Value driven to the pad |
| padOe | output | 1 | Pad output enable, active high |
| padPullUp | output | 1 | Pull-up resistor enable |
| padPullDn | output | 1 | Pull-down resistor enable |
| driveCode | output | 3 | Stored drive-strength and slew code |
| funcIn | output | 8 | Pad input level sent to each function |
| edgeFlag | output | 1 | Sticky edge-event flag |
| wakeReq | output | 1 | Wake request |

## Verification
The assertions check four things on every cycle. Reserved bits stay zero. The event flag holds once set unless a clear is in progress. A clear write always empties the flag on the next clock. The flag never rises without an enabled polarity and no clear active. With the low-power override active, they also check that the pad output holds steady while the stored sleep value holds, and that a wake request never appears without the flag. Only the bench scenarios can show that the correct function is routed for each selector value and which pull source wins. They also show the exact three-cycle edge latency, that an edge of a disabled polarity is ignored, and that detection resumes once the clear bit is dropped.

// File: rtl/pad_mux_pkg.sv
package pad_mux_pkg;

  localparam int CFG_W   = 32;
  localparam int SEL_W   = 3;
  localparam int DRIVE_W = 3;

  // Field positions inside the configuration word
  localparam int SEL_LSB    = 0;
  localparam int RISE_BIT   = 4;
  localparam int FALL_BIT   = 5;
  localparam int CLR_BIT    = 6;
  localparam int LPOEN_BIT  = 7;
  localparam int LPDATA_BIT = 8;
  localparam int LPSEL_BIT  = 9;
  localparam int DRV_LSB    = 10;
  localparam int PDN_BIT    = 13;
  localparam int PUP_BIT    = 14;
  localparam int PSRC_BIT   = 15;
  localparam int USED_W     = 16;

  // Writable bits: low half-word minus the reserved bit 3
  localparam logic [CFG_W-1:0] CFG_WRITE_MASK =
    {{(CFG_W-USED_W){1'b0}}, {USED_W{1'b1}}} & ~(CFG_W'(1) << 3);

  // Strobes and levels handed from control to the datapath
  typedef struct packed {
    logic [SEL_W-1:0] funcSel;
    logic             lpOverride;
    logic             lpData;
    logic             lpOeN;
    logic             pullSel;
    logic             pullUpEn;
    logic             pullDnEn;
  } padCtlT;

endpackage

// File: rtl/pad_edge_detect.sv
module pad_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic padIn,
  input  logic riseEn,
  input  logic fallEn,
  input  logic clrHold,
  input  logic clrPulse,
  output logic edgeFlag
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   syncLevel;
  logic                   sawRise;
  logic                   sawFall;
  logic                   hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], padIn};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign syncLevel = syncQ[SYNC_STAGES-1];
  assign sawRise   = syncLevel & ~prevQ;
  assign sawFall   = ~syncLevel & prevQ;
  assign hit       = (riseEn & sawRise) | (fallEn & sawFall);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   edgeFlag <= 1'b0;
    else if (clrPulse || clrHold) edgeFlag <= 1'b0;
    else if (hit)                edgeFlag <= 1'b1;
  end

  p_flag_sticky_r8 : assert property (@(posedge clk) disable iff (!rstN)
    (edgeFlag && !clrPulse && !clrHold) |=> edgeFlag);

  p_clear_empties_r9 : assert property (@(posedge clk) disable iff (!rstN)
    clrPulse |=> !edgeFlag);

  p_rise_needs_enable_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (!edgeFlag && !(riseEn || fallEn)) |=> !edgeFlag);

endmodule

// File: rtl/pad_cfg_ctrl.sv
module pad_cfg_ctrl
  import pad_mux_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [CFG_W-1:0]   cfgWdata,
  input  logic               padIn,
  output logic [CFG_W-1:0]   cfgRdata,
  output logic [DRIVE_W-1:0] driveCode,
  output padCtlT             ctl,
  output logic               edgeFlag
);

  logic [CFG_W-1:0] cfgQ;
  logic             clrPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfgWdata & CFG_WRITE_MASK;
  end

  assign cfgRdata  = cfgQ;
  assign driveCode = cfgQ[DRV_LSB +: DRIVE_W];
  assign clrPulse  = cfgWe & cfgWdata[CLR_BIT];

  always_comb begin
    ctl.funcSel    = cfgQ[SEL_LSB +: SEL_W];
    ctl.lpOverride = cfgQ[LPSEL_BIT];
    ctl.lpData     = cfgQ[LPDATA_BIT];
    ctl.lpOeN      = cfgQ[LPOEN_BIT];
    ctl.pullSel    = cfgQ[PSRC_BIT];
    ctl.pullUpEn   = cfgQ[PUP_BIT];
    ctl.pullDnEn   = cfgQ[PDN_BIT];
  end

  pad_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rstN     (rstN),
    .padIn    (padIn),
    .riseEn   (cfgQ[RISE_BIT]),
    .fallEn   (cfgQ[FALL_BIT]),
    .clrHold  (cfgQ[CLR_BIT]),
    .clrPulse (clrPulse),
    .edgeFlag (edgeFlag)
  );

  p_reserved_zero_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata[CFG_W-1:USED_W] == '0) && (cfgRdata[3] == 1'b0));

endmodule

// File: rtl/pad_route_dp.sv
module pad_route_dp
  import pad_mux_pkg::*;
#(
  parameter int NUM_FUNC = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  padCtlT              ctl,
  input  logic                lowPowerMode,
  input  logic [NUM_FUNC-1:0] funcOut,
  input  logic [NUM_FUNC-1:0] funcOe,
  input  logic [NUM_FUNC-1:0] funcPullUp,
  input  logic [NUM_FUNC-1:0] funcPullDn,
  input  logic                padIn,
  output logic                padOut,
  output logic                padOe,
  output logic                padPullUp,
  output logic                padPullDn,
  output logic [NUM_FUNC-1:0] funcIn
);

  logic selOut;
  logic selOe;
  logic selPu;
  logic selPd;
  logic sleepActive;

  assign selOut = funcOut[ctl.funcSel];
  assign selOe  = funcOe[ctl.funcSel];
  assign selPu  = funcPullUp[ctl.funcSel];
  assign selPd  = funcPullDn[ctl.funcSel];

  assign sleepActive = lowPowerMode & ctl.lpOverride;

  always_comb begin
    if (sleepActive) begin
      padOut = ctl.lpData;
      padOe  = ~ctl.lpOeN;
    end else begin
      padOut = selOut;
      padOe  = selOe;
    end
  end

  always_comb begin
    if (ctl.pullSel) begin
      padPullUp = ctl.pullUpEn;
      padPullDn = ctl.pullDnEn;
    end else begin
      padPullUp = selPu;
      padPullDn = selPd;
    end
  end

  for (genvar i = 0; i < NUM_FUNC; i++) begin : g_fanout
    assign funcIn[i] = padIn;
  end

  p_sleep_steady_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (sleepActive && $past(sleepActive) && $stable(ctl.lpData) && $stable(ctl.lpOeN))
      |-> ($stable(padOut) && $stable(padOe)));

endmodule

// File: rtl/pad_mux_cell.sv
module pad_mux_cell
  import pad_mux_pkg::*;
#(
  parameter int NUM_FUNC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CFG_W-1:0]    cfgWdata,
  output logic [CFG_W-1:0]    cfgRdata,
  input  logic                lowPowerMode,
  input  logic                wakeEnable,
  input  logic [NUM_FUNC-1:0] funcOut,
  input  logic [NUM_FUNC-1:0] funcOe,
  input  logic [NUM_FUNC-1:0] funcPullUp,
  input  logic [NUM_FUNC-1:0] funcPullDn,
  input  logic                padIn,
  output logic                padOut,
  output logic                padOe,
  output logic                padPullUp,
  output logic                padPullDn,
  output logic [DRIVE_W-1:0]  driveCode,
  output logic [NUM_FUNC-1:0] funcIn,
  output logic                edgeFlag,
  output logic                wakeReq
);

  padCtlT ctl;

  pad_cfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgWdata  (cfgWdata),
    .padIn     (padIn),
    .cfgRdata  (cfgRdata),
    .driveCode (driveCode),
    .ctl       (ctl),
    .edgeFlag  (edgeFlag)
  );

  pad_route_dp #(.NUM_FUNC(NUM_FUNC)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .lowPowerMode (lowPowerMode),
    .funcOut      (funcOut),
    .funcOe       (funcOe),
    .funcPullUp   (funcPullUp),
    .funcPullDn   (funcPullDn),
    .padIn        (padIn),
    .padOut       (padOut),
    .padOe        (padOe),
    .padPullUp    (padPullUp),
    .padPullDn    (padPullDn),
    .funcIn       (funcIn)
  );

  assign wakeReq = edgeFlag & wakeEnable;

  p_wake_gated_r10 : assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (edgeFlag && wakeEnable));

endmodule

// File: tb/pad_mux_cell_tb.sv
module pad_mux_cell_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe;
  logic [31:0] cfgWdata;
  logic [31:0] cfgRdata;
  logic        lowPowerMode;
  logic        wakeEnable;
  logic [7:0]  funcOut, funcOe, funcPullUp, funcPullDn;
  logic        padIn;
  logic        padOut, padOe, padPullUp, padPullDn;
  logic [2:0]  driveCode;
  logic [7:0]  funcIn;
  logic        edgeFlag, wakeReq;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pad_mux_cell u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .lowPowerMode(lowPowerMode), .wakeEnable(wakeEnable),
    .funcOut(funcOut), .funcOe(funcOe), .funcPullUp(funcPullUp), .funcPullDn(funcPullDn),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPullUp(padPullUp),
    .padPullDn(padPullDn), .driveCode(driveCode), .funcIn(funcIn),
    .edgeFlag(edgeFlag), .wakeReq(wakeReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrCfg(input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0; cfgWdata = '0;
    #1;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic testReset();
    funcOut = 8'h01; funcOe = 8'h01; #1;
    chk("R1 cfg", cfgRdata, 32'h0);
    chk("R1 flag", {31'b0, edgeFlag}, 32'h0);
    chk("R1 wake", {31'b0, wakeReq}, 32'h0);
    chk("R1 padOut", {31'b0, padOut}, 32'h1);
    chk("R1 padOe", {31'b0, padOe}, 32'h1);
  endtask

  task automatic testReadback();
    wrCfg(32'hFFFF_FFFF);
    chk("R2 reserved", cfgRdata, 32'h0000_FFF7);
    chk("R11 drive all", {29'b0, driveCode}, 32'h7);
    wrCfg(32'h0000_1400);
    chk("R2 readback", cfgRdata, 32'h0000_1400);
    chk("R11 drive 101", {29'b0, driveCode}, 32'h5);
  endtask

  task automatic testMux();
    funcOut = 8'hA5; funcOe = 8'h3C;
    for (int s = 0; s < 8; s++) begin
      wrCfg(32'(s));
      chk("R3 padOut", {31'b0, padOut}, {31'b0, funcOut[s]});
      chk("R3 padOe", {31'b0, padOe}, {31'b0, funcOe[s]});
    end
  endtask

  task automatic testPull();
    funcPullUp = 8'h0F; funcPullDn = 8'hF0;
    wrCfg(32'h2);
    chk("R4 fn up sel2", {31'b0, padPullUp}, 32'h1);
    chk("R4 fn dn sel2", {31'b0, padPullDn}, 32'h0);
    wrCfg(32'h6);
    chk("R4 fn up sel6", {31'b0, padPullUp}, 32'h0);
    chk("R4 fn dn sel6", {31'b0, padPullDn}, 32'h1);
    wrCfg(32'hC006);
    chk("R4 reg up", {31'b0, padPullUp}, 32'h1);
    chk("R4 reg dn off", {31'b0, padPullDn}, 32'h0);
    wrCfg(32'hA006);
    chk("R4 reg up off", {31'b0, padPullUp}, 32'h0);
    chk("R4 reg dn", {31'b0, padPullDn}, 32'h1);
  endtask

  task automatic testLowPower();
    funcOut = 8'h00; funcOe = 8'h00;
    wrCfg(32'h301);
    chk("R5 awake fn", {31'b0, padOut}, 32'h0);
    lowPowerMode = 1'b1; #1;
    chk("R5 sleep data", {31'b0, padOut}, 32'h1);
    chk("R5 sleep oe", {31'b0, padOe}, 32'h1);
    wrCfg(32'h281);
    chk("R5 sleep data0", {31'b0, padOut}, 32'h0);
    chk("R5 sleep oe off", {31'b0, padOe}, 32'h0);
    funcOut = 8'h02; funcOe = 8'h02;
    wrCfg(32'h101);
    chk("R5 no override out", {31'b0, padOut}, 32'h1);
    chk("R5 no override oe", {31'b0, padOe}, 32'h1);
    lowPowerMode = 1'b0;
  endtask

  task automatic clearFlag(input logic [31:0] keep);
    wrCfg(keep | 32'h40);
    wrCfg(keep);
  endtask

  task automatic testRise();
    wrCfg(32'h10);
    @(negedge clk); padIn = 1'b1;
    waitCyc(2);
    chk("R6 not yet", {31'b0, edgeFlag}, 32'h0);
    waitCyc(1);
    chk("R6 rise set", {31'b0, edgeFlag}, 32'h1);
    @(negedge clk); padIn = 1'b0;
    waitCyc(4);
    chk("R8 sticky", {31'b0, edgeFlag}, 32'h1);
    clearFlag(32'h10);
    chk("R9 cleared", {31'b0, edgeFlag}, 32'h0);
    @(negedge clk); padIn = 1'b1;
    waitCyc(4);
    @(negedge clk); padIn = 1'b0;
    waitCyc(4);
    chk("R8 fall ignored", {31'b0, edgeFlag}, 32'h1);
    clearFlag(32'h10);
    @(negedge clk); padIn = 1'b1;
    waitCyc(4);
    clearFlag(32'h10);
    @(negedge clk); padIn = 1'b0;
    waitCyc(4);
    chk("R8 fall ignored rise-only", {31'b0, edgeFlag}, 32'h0);
  endtask

  task automatic testFall();
    wrCfg(32'h20);
    @(negedge clk); padIn = 1'b1;
    waitCyc(4);
    chk("R8 rise ignored fall-only", {31'b0, edgeFlag}, 32'h0);
    @(negedge clk); padIn = 1'b0;
    waitCyc(2);
    chk("R7 not yet", {31'b0, edgeFlag}, 32'h0);
    waitCyc(1);
    chk("R7 fall set", {31'b0, edgeFlag}, 32'h1);
    clearFlag(32'h30);
    @(negedge clk); padIn = 1'b1;
    waitCyc(3);
    chk("R7 both rise", {31'b0, edgeFlag}, 32'h1);
    clearFlag(32'h30);
    @(negedge clk); padIn = 1'b0;
    waitCyc(3);
    chk("R7 both fall", {31'b0, edgeFlag}, 32'h1);
  endtask

  task automatic testClearHold();
    wrCfg(32'h70);
    chk("R9 clear write", {31'b0, edgeFlag}, 32'h0);
    @(negedge clk); padIn = 1'b1;
    waitCyc(4);
    @(negedge clk); padIn = 1'b0;
    waitCyc(4);
    chk("R9 held blocks", {31'b0, edgeFlag}, 32'h0);
    wrCfg(32'h30);
    @(negedge clk); padIn = 1'b1;
    waitCyc(3);
    chk("R9 resumes", {31'b0, edgeFlag}, 32'h1);
  endtask

  task automatic testWake();
    wakeEnable = 1'b0; #1;
    chk("R10 gated", {31'b0, wakeReq}, 32'h0);
    wakeEnable = 1'b1; #1;
    chk("R10 wake", {31'b0, wakeReq}, 32'h1);
    clearFlag(32'h30);
    chk("R10 no flag", {31'b0, wakeReq}, 32'h0);
    wakeEnable = 1'b0;
  endtask

  task automatic testFanout();
    wrCfg(32'h5);
    padIn = 1'b1; #1;
    chk("R12 high", {24'b0, funcIn}, 32'hFF);
    padIn = 1'b0; #1;
    chk("R12 low", {24'b0, funcIn}, 32'h00);
  endtask

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgWdata = '0; lowPowerMode = 1'b0; wakeEnable = 1'b0;
    funcOut = '0; funcOe = '0; funcPullUp = '0; funcPullDn = '0; padIn = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk); #1;
    testReadback();
    testMux();
    testPull();
    testLowPower();
    testRise();
    testFall();
    testClearHold();
    testWake();
    testFanout();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule